// File: doc/BRIEF.md
# Glitch-Free CPU Clock Speed Switcher

This block picks the processor clock from five free-running source clocks. All five come from one 3.6864 MHz reference, at nominal rates of 18.432, 36.864, 49.152, 73.728 and 90.3168 MHz. Software writes a speed code through a small valid/ready configuration port. The block then moves the processor clock from the old source to the new one. First it gates the outgoing source off on its own falling edge. It waits until that gate is confirmed closed, parks the output low and changes its bus-clock mode. Only then does it open the incoming source on that clock's falling edge. Because of this order, no runt pulse reaches the CPU clock output.

The block also produces the external bus clock. For the slowest speed the bus clock is the CPU clock itself (18.432 MHz). For every speed of 36 MHz or above it is the CPU clock divided by two. The divider is cleared while the output is parked, so after a handover it starts on a full-length high phase.

The configuration port runs on its own clock, `cfg_clk`, and moves one word per `cfg_valid && cfg_ready` handshake. `cfg_ready` is low for as long as a handover is in progress. A word presented during that time is not taken, and the writer has to hold or retry it. A word that is accepted is never queued: it is either acted on at once or dropped.

Top module: `cpu_clk_switcher`

## Requirements
- R1: After reset the speed code is 0. `cpu_clk` runs at 18.432 MHz, `bus_clk` at 18.432 MHz, `busy` is 0 and `cfg_ready` is 1.
- R2: An accepted write of code c in 0..4 selects source c. Code 0 is 18.432, 1 is 36.864, 2 is 49.152, 3 is 73.728 and 4 is 90.3168 MHz, and `cpu_clk` then runs at that rate.
- R3: During a handover the old enable falls on the old clock's falling edge, and the output stays low until the new enable rises on the new clock's falling edge. No high or low phase of `cpu_clk` or `bus_clk` is shorter than half the period of the faster of the two clocks involved.
- R4: An accepted word with code 5, 6 or 7 is ignored: `busy` stays low and the clock rate does not change.
- R5: `cfg_ready` is low while `busy` is high. A word presented then is not taken and has no effect on the selection.
- R6: `busy` rises in the cycle after a write that starts a handover, and it stays high until the new source's enable is seen on.
- R7: With code 0, `bus_clk` equals `cpu_clk`. With codes 1 to 4, `bus_clk` is `cpu_clk` divided by two. The bus mode changes only while the output is parked low.
- R8: After a handover to a code of 1 to 4, the first high phase of `bus_clk` lasts one full period of the new CPU clock.
- R9: At most one source enable is on at any time.
- R10: Writing the code already selected is accepted but starts no handover: `busy` stays low and the rate does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| src_clk | input | N_SRC | Source clocks, bit i is speed code i |
| cfg_valid | input | 1 | Configuration word present |
| cfg_ready | output | 1 | Word accepted on this edge when valid is high |
| cfg_data | input | CODE_W | Requested speed code |
| cpu_clk | output | 1 | Selected processor clock |
| bus_clk | output | 1 | External bus clock |
| busy | output | 1 | Handover in progress |

## Verification
The assertions check on every cycle that at most one source is enabled and that both outputs are low while parked. They also check that the bus mode flips only while parked, that no old enable is still seen when the new one is requested, and that a rejected or ignored word leaves the selection untouched. Only the bench's scenarios can show the actual clock rates after each switch, the length of every clock phase across all transitions, and that the first bus high phase after a switch is full length. These depend on real edge timing between unrelated clocks.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DROP  = 3'd1,
    ST_PARK  = 3'd2,
    ST_SWAP  = 3'd3,
    ST_RAISE = 3'd4
  } sw_state_e;
endpackage

// File: rtl/clksw_gate.sv
module clksw_gate #(
  parameter bit RST_ON = 1'b0
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic req,
  output logic en,
  output logic gclk
);
  logic [1:0] sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {2{RST_ON}};
    else        sync_q <= {sync_q[0], req};
  end

  // enable only changes while the source is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en <= RST_ON;
    else        en <= sync_q[1];
  end

  assign gclk = src_clk & en;

  // R3
  en_req_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(en) |-> req);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl #(
  parameter int N_SRC  = 5,
  parameter int CODE_W = 3
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CODE_W-1:0] cfg_data,
  input  logic [N_SRC-1:0]  en_raw,
  output logic [N_SRC-1:0]  req,
  output logic              hold,
  output logic              half_mode,
  output logic              busy
);
  import clksw_pkg::*;

  localparam logic [N_SRC-1:0] BOOT_SEL = {{(N_SRC-1){1'b0}}, 1'b1};

  function automatic logic [N_SRC-1:0] code_mask(input logic [CODE_W-1:0] c);
    logic [N_SRC-1:0] m;
    m = '0;
    for (int i = 0; i < N_SRC; i++) if (c == CODE_W'(i)) m[i] = 1'b1;
    return m;
  endfunction

  sw_state_e         st_q, st_n;
  logic [CODE_W-1:0] cur_q, cur_n, tgt_q, tgt_n;
  logic [N_SRC-1:0]  ack_q1, ack_q2;
  logic              accept, code_ok;

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q1 <= BOOT_SEL;
      ack_q2 <= BOOT_SEL;
    end else begin
      ack_q1 <= en_raw;
      ack_q2 <= ack_q1;
    end
  end

  assign accept  = cfg_valid && !busy;
  assign code_ok = int'(cfg_data) < N_SRC;

  always_comb begin
    st_n  = st_q;
    cur_n = cur_q;
    tgt_n = tgt_q;
    unique case (st_q)
      ST_IDLE: if (accept && code_ok && cfg_data != cur_q) begin
        tgt_n = cfg_data;
        st_n  = ST_DROP;
      end
      ST_DROP:  if (ack_q2 == '0) st_n = ST_PARK;
      ST_PARK: begin
        cur_n = tgt_q;
        st_n  = ST_SWAP;
      end
      ST_SWAP:  st_n = ST_RAISE;
      ST_RAISE: if (|(ack_q2 & code_mask(cur_q))) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_q     <= '0;
      tgt_q     <= '0;
      req       <= BOOT_SEL;
      hold      <= 1'b0;
      half_mode <= 1'b0;
      busy      <= 1'b0;
    end else begin
      st_q      <= st_n;
      cur_q     <= cur_n;
      tgt_q     <= tgt_n;
      req       <= (st_n == ST_IDLE || st_n == ST_RAISE) ? code_mask(cur_n) : '0;
      hold      <= (st_n == ST_PARK || st_n == ST_SWAP);
      half_mode <= (cur_n != '0);
      busy      <= (st_n != ST_IDLE);
    end
  end

  // R4
  bad_code_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_valid && !busy && !code_ok) |=> (!busy && cur_q == $past(cur_q)));
  // R5
  busy_drop_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_valid && busy) |=> (tgt_q == $past(tgt_q)));
  // R6
  accept_busy_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_valid && !busy && code_ok && cfg_data != cur_q) |=> busy);
  // R10
  same_code_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_valid && !busy && cfg_data == cur_q) |=> !busy);
  // R7
  mode_park_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (half_mode != $past(half_mode)) |-> hold);
  // R3
  raise_clean_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (st_q == ST_RAISE) |-> ((ack_q2 & ~code_mask(cur_q)) == '0));
endmodule

// File: rtl/clksw_busdiv.sv
module clksw_busdiv (
  input  logic cpu_clk,
  input  logic rst_n,
  input  logic hold,
  input  logic half_mode,
  output logic bus_clk
);
  logic div_q;

  always_ff @(posedge cpu_clk or negedge rst_n or posedge hold) begin
    if (!rst_n)    div_q <= 1'b0;
    else if (hold) div_q <= 1'b0;
    else           div_q <= ~div_q;
  end

  assign bus_clk = half_mode ? div_q : cpu_clk;
endmodule

// File: rtl/cpu_clk_switcher.sv
module cpu_clk_switcher #(
  parameter int N_SRC  = 5,
  parameter int CODE_W = $clog2(N_SRC)
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_clk,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [CODE_W-1:0] cfg_data,
  output logic              cpu_clk,
  output logic              bus_clk,
  output logic              busy
);
  logic [N_SRC-1:0] req, en, gclk;
  logic             hold, half_mode;

  clksw_ctrl #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_ctrl (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_data  (cfg_data),
    .en_raw    (en),
    .req       (req),
    .hold      (hold),
    .half_mode (half_mode),
    .busy      (busy)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    clksw_gate #(.RST_ON(g == 0)) u_gate (
      .src_clk (src_clk[g]),
      .rst_n   (rst_n),
      .req     (req[g]),
      .en      (en[g]),
      .gclk    (gclk[g])
    );
  end

  assign cpu_clk   = |gclk;
  assign cfg_ready = !busy;

  clksw_busdiv u_div (
    .cpu_clk   (cpu_clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .half_mode (half_mode),
    .bus_clk   (bus_clk)
  );

  // R9
  single_src_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $onehot0(en));
  // R3
  park_low_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    hold |-> (!cpu_clk && !bus_clk && en == '0));
endmodule

// File: tb/tb_cpu_clk_switcher.sv
`timescale 1ns/1ps
module tb_cpu_clk_switcher;
  logic       cfg_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_clk = '0;
  logic       cfg_valid = 1'b0;
  logic [2:0] cfg_data = '0;
  logic       cfg_ready, cpu_clk, bus_clk, busy;

  int  n_tests = 0, n_fail = 0, cyc = 0;
  bit  done = 0;

  cpu_clk_switcher dut (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .src_clk(src_clk),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .cpu_clk(cpu_clk), .bus_clk(bus_clk), .busy(busy)
  );

  function automatic real per_of(int c);
    case (c)
      0: return 54.2535;
      1: return 27.1267;
      2: return 20.3451;
      3: return 13.5634;
      default: return 11.0720;
    endcase
  endfunction

  always #2.5 cfg_clk = ~cfg_clk;
  initial forever #(27.12675) src_clk[0] = ~src_clk[0];
  initial forever #(13.56335) src_clk[1] = ~src_clk[1];
  initial forever #(10.17255) src_clk[2] = ~src_clk[2];
  initial forever #(6.7817)   src_clk[3] = ~src_clk[3];
  initial forever #(5.536)    src_clk[4] = ~src_clk[4];

  // phase monitor
  real thr = 5.0, gap_thr = 1.0e9;
  bit  mon_on = 0, restart_seen = 0, got_first = 0;
  real last_c = 0.0, last_b = 0.0, t_restart = 0.0, first_hi = 0.0;
  int  glitches = 0;

  always @(cpu_clk) begin
    if (mon_on && ($realtime - last_c) < thr) glitches++;
    if (mon_on && cpu_clk && ($realtime - last_c) > gap_thr && !restart_seen) begin
      restart_seen = 1;
      t_restart = $realtime;
    end
    last_c = $realtime;
  end

  always @(bus_clk) begin
    if (mon_on && ($realtime - last_b) < thr) glitches++;
    if (mon_on && !bus_clk && restart_seen && !got_first) begin
      first_hi = $realtime - t_restart;
      got_first = 1;
    end
    last_b = $realtime;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input real act, input real exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", rq, what, act, exp);
    end
  endtask

  function automatic bit near(real a, real b);
    return (a - b < 0.05) && (b - a < 0.05);
  endfunction

  task automatic measure(output real pc, output real pb);
    real t0;
    @(posedge cpu_clk); t0 = $realtime;
    @(posedge cpu_clk); pc = $realtime - t0;
    @(posedge bus_clk); t0 = $realtime;
    @(posedge bus_clk); pb = $realtime - t0;
  endtask

  task automatic write_code(input int c, output bit acc);
    @(negedge cfg_clk);
    cfg_valid = 1'b1;
    cfg_data  = 3'(c);
    acc = cfg_ready;
    @(posedge cfg_clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(posedge cfg_clk);
    #1;
  endtask

  task automatic check_rate(input int c, input string rq);
    real pc, pb, eb;
    measure(pc, pb);
    eb = (c == 0) ? per_of(0) : 2.0 * per_of(c);
    chk(near(pc, per_of(c)), rq, "cpu period", pc, per_of(c));
    chk(near(pb, eb), "R7", "bus period", pb, eb);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy after reset", real'(busy), 0.0);
    chk(cfg_ready == 1'b1, "R1", "ready after reset", real'(cfg_ready), 1.0);
    check_rate(0, "R1");
  endtask

  task automatic t_switch(input int from, input int to);
    bit acc;
    int g0;
    real pf, pslow;
    pf    = (per_of(from) < per_of(to)) ? per_of(from) : per_of(to);
    pslow = (per_of(from) > per_of(to)) ? per_of(from) : per_of(to);
    thr = 0.5 * pf - 0.05;
    gap_thr = 0.75 * pslow;
    restart_seen = 0;
    got_first = 0;
    g0 = glitches;
    write_code(to, acc);
    chk(acc, "R6", "write accepted", real'(acc), 1.0);
    chk(busy == 1'b1, "R6", "busy after write", real'(busy), 1.0);
    wait_idle();
    chk(busy == 1'b0, "R6", "busy clears", real'(busy), 0.0);
    #(per_of(to));
    chk(restart_seen, "R6", "new clock running", real'(restart_seen), 1.0);
    check_rate(to, "R2");
    chk(glitches == g0, "R3", "short phases", real'(glitches - g0), 0.0);
    if (to != 0)
      chk(got_first && near(first_hi, per_of(to)), "R8", "first bus high",
          first_hi, per_of(to));
  endtask

  task automatic t_bad_code(input int cur, input int bad);
    bit acc;
    write_code(bad, acc);
    chk(acc, "R4", "bad code handshake", real'(acc), 1.0);
    chk(busy == 1'b0, "R4", "busy stays low", real'(busy), 0.0);
    repeat (4) @(posedge cfg_clk);
    #1;
    chk(busy == 1'b0, "R4", "busy later", real'(busy), 0.0);
    check_rate(cur, "R4");
  endtask

  task automatic t_busy_write(input int from, input int to, input int other);
    bit acc;
    int g0;
    real pf;
    pf = (per_of(from) < per_of(to)) ? per_of(from) : per_of(to);
    thr = 0.5 * pf - 0.05;
    g0 = glitches;
    write_code(to, acc);
    write_code(other, acc);
    chk(!acc, "R5", "ready low while busy", real'(acc), 0.0);
    wait_idle();
    check_rate(to, "R5");
    chk(glitches == g0, "R3", "short phases", real'(glitches - g0), 0.0);
  endtask

  task automatic t_same(input int cur);
    bit acc;
    write_code(cur, acc);
    chk(acc && busy == 1'b0, "R10", "same code no busy", real'(busy), 0.0);
    check_rate(cur, "R10");
  endtask

  always @(posedge cfg_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #100;
    @(negedge cfg_clk);
    rst_n = 1'b1;
    repeat (4) @(posedge cfg_clk);
    @(posedge cpu_clk); #0.01;
    last_c = $realtime; last_b = $realtime;
    thr = 0.5 * per_of(0) - 0.05;
    mon_on = 1;
    t_reset();
    t_switch(0, 1);
    t_switch(1, 2);
    t_switch(2, 3);
    t_switch(3, 4);
    t_bad_code(4, 6);
    t_switch(4, 0);
    t_bad_code(0, 5);
    t_switch(0, 4);
    t_same(4);
    t_busy_write(4, 2, 0);
    t_switch(2, 0);
    t_switch(0, 3);
    t_bad_code(3, 7);
    t_switch(3, 1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule